// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block collects a parameterized number of level-sensitive interrupt sources and delivers them to up to four processors. Each source passes a global enable and a per-source routing selection, and then the mask of the processor that would receive it. Each processor has one interrupt output and an acknowledge register. Reading the acknowledge register tells the processor which source to service. The read does not claim the source. A source stays pending until its input line falls.

Software uses a simple register bus. Every access carries the number of the processor making it, so the per-processor registers (mask set, mask clear, acknowledge) share one address. Enables and masks are changed by writing a source index to a set register or a clear register, so no read-modify-write is needed. Sources 3 and 5 are private to each processor: only that processor's own mask gates them. Sources 0 and 1 are ordinary level inputs here. They are expected to carry the doorbell summaries from elsewhere in the chip.

Top module: `irq_router`

## Requirements
- R1: After reset all global enables are clear, every processor mask bit is set, every source routes to processor 0 only (control value 0x001), every acknowledge reads 1023 and `irq_o` is low. This holds even while sources are high.
- R2: A read of offset 0x000 returns the number of implemented sources in bits [11:2], with all other bits zero.
- R3: Writing a source index (wdata bits [9:0]) to offset 0x030 sets that source's global enable, and writing it to offset 0x034 clears it. An index at or above the source count is ignored and does not alias onto a lower source.
- R4: Writing a source index to offset 0x048 sets the mask bit of the accessing processor (`cpu_i`) for that source, and writing it to 0x04C clears that bit. The masks of other processors are unchanged.
- R5: The control register of source i sits at offset 0x100 + 4*i. Bit n routes the source to processor n as a normal request and bit 8+n routes it as a fast request, and either bit makes the source deliverable to processor n. Only these bits are stored. All other bits read as zero.
- R6: Sources 3 and 5 are private. For processor n such a source is eligible when its input is high and processor n's mask bit is clear, whatever its global enable and routing bits hold.
- R7: Offset 0x044 returns, in bits [9:0], the lowest-numbered source that is eligible for the accessing processor, or 1023 when none is eligible. Bits [31:10] read zero. A global source is eligible for processor n when it is high, enabled, routed to n and not masked by n.
- R8: `irq_o[n]` is registered. It goes high on the clock edge after a source becomes eligible for processor n, and it falls on the edge after no source is eligible any more.
- R9: Reading the acknowledge register has no side effect. Repeated reads return the same ID, and an eligible source stops being reported only when its input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| cpu_i | input | CPU_W (2) | Number of the processor making the access |
| addr_i | input | ADDR_W (12) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i and cpu_i |
| src_i | input | NUM_SRC (32) | Level interrupt source inputs |
| irq_o | output | NUM_CPU (4) | Interrupt request, one per processor |

## Verification
The hardest condition to reach is one where several sources are eligible at once, each for a different subset of processors. It takes global routing, fast-request routing, private sources and distinct per-processor masks all meeting in the same cycle. The bench first builds an asymmetric configuration: each processor gets a different unmask set and the sources get different route bits. A table of source patterns is then applied, and every processor's acknowledge ID and interrupt line are checked for each pattern. Directed tests follow for index aliasing on writes, for one processor's mask write leaving the others alone, and for the one-cycle lag of the output register.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ID_W    = 10;
  localparam int unsigned DATA_W  = 32;
  localparam logic [ID_W-1:0] NONE_ID = '1;  // 1023: nothing pending

  localparam int unsigned OFF_CTRL     = 'h000;
  localparam int unsigned OFF_EN_SET   = 'h030;
  localparam int unsigned OFF_EN_CLR   = 'h034;
  localparam int unsigned OFF_ACK      = 'h044;
  localparam int unsigned OFF_MASK_SET = 'h048;
  localparam int unsigned OFF_MASK_CLR = 'h04C;
  localparam int unsigned OFF_SRC_BASE = 'h100;
  localparam int unsigned FAST_LSB     = 8;

  function automatic bit is_private(int unsigned s);
    return (s == 3) || (s == 5);
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [CPU_W-1:0]                    cpu_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  input  logic [NUM_CPU-1:0][ID_W-1:0]        ack_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic [NUM_SRC-1:0]                  en_o,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]     mask_o,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]     route_o
);
  localparam logic [ID_W-1:0]     SRC_CNT   = ID_W'(NUM_SRC);
  localparam logic [ADDR_W-3:0]   SRC_CNT_A = (ADDR_W-2)'(NUM_SRC);
  localparam logic [CPU_W:0]      CPU_CNT   = (CPU_W+1)'(NUM_CPU);

  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] nrm_q, fst_q;

  logic [ID_W-1:0]   idx;
  logic [SRC_W-1:0]  idx_s;
  logic              idx_ok, cpu_ok, wr, in_src;
  logic [ADDR_W-1:0] src_off;
  logic [ADDR_W-3:0] src_num;
  logic [SRC_W-1:0]  sel;

  assign idx     = wdata_i[ID_W-1:0];
  assign idx_s   = idx[SRC_W-1:0];
  assign idx_ok  = idx < SRC_CNT;
  assign cpu_ok  = {1'b0, cpu_i} < CPU_CNT;
  assign wr      = req_i && we_i;
  assign src_off = addr_i - ADDR_W'(OFF_SRC_BASE);
  assign src_num = src_off[ADDR_W-1:2];
  assign sel     = src_num[SRC_W-1:0];
  assign in_src  = (addr_i >= ADDR_W'(OFF_SRC_BASE)) && (src_off[1:0] == 2'b00)
                   && (src_num < SRC_CNT_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '1;
      fst_q  <= '0;
      for (int s = 0; s < NUM_SRC; s++) nrm_q[s] <= NUM_CPU'(1);
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFF_EN_SET) && idx_ok) en_q[idx_s] <= 1'b1;
      if (addr_i == ADDR_W'(OFF_EN_CLR) && idx_ok) en_q[idx_s] <= 1'b0;
      if (addr_i == ADDR_W'(OFF_MASK_SET) && idx_ok && cpu_ok) mask_q[cpu_i][idx_s] <= 1'b1;
      if (addr_i == ADDR_W'(OFF_MASK_CLR) && idx_ok && cpu_ok) mask_q[cpu_i][idx_s] <= 1'b0;
      if (in_src) begin
        nrm_q[sel] <= wdata_i[NUM_CPU-1:0];
        fst_q[sel] <= wdata_i[FAST_LSB +: NUM_CPU];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      rdata_o[2 +: ID_W] = SRC_CNT;
    end else if (addr_i == ADDR_W'(OFF_ACK)) begin
      rdata_o[ID_W-1:0] = cpu_ok ? ack_i[cpu_i] : NONE_ID;
    end else if (in_src) begin
      rdata_o[NUM_CPU-1:0]           = nrm_q[sel];
      rdata_o[FAST_LSB +: NUM_CPU]   = fst_q[sel];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
    assign route_o[s] = nrm_q[s] | fst_q[s];
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

  logic unused_bits;
  assign unused_bits = ^{wdata_i, src_off[1:0]};

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_EN_SET) && idx_ok) |=> en_q[$past(idx_s)]);  // R3
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_EN_CLR) && idx_ok) |=> !en_q[$past(idx_s)]);  // R3
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_MASK_CLR) && idx_ok && cpu_ok)
    |=> !mask_q[$past(cpu_i)][$past(idx_s)]);  // R4
  AST_EN_BAD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !idx_ok) |=> $stable(en_q));  // R3
endmodule

// File: rtl/irq_router_sel.sv
module irq_router_sel
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] elig_i,
  output logic [ID_W-1:0]    id_o,
  output logic               hit_o
);
  always_comb begin
    id_o  = NONE_ID;
    hit_o = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        id_o  = ID_W'(i);
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [CPU_W-1:0]     cpu_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_SRC-1:0]   src_i,
  output logic [NUM_CPU-1:0]   irq_o
);
  localparam logic [ID_W-1:0] SRC_CNT = ID_W'(NUM_SRC);

  logic [NUM_SRC-1:0]              en;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] elig;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack;
  logic [NUM_CPU-1:0]              hit;
  logic [NUM_CPU-1:0]              irq_q;

  irq_router_regs #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .cpu_i, .addr_i, .wdata_i,
    .ack_i(ack), .rdata_o, .en_o(en), .mask_o(mask), .route_o(route)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (is_private(s)) begin : g_priv
        assign elig[c][s] = src_i[s] & ~mask[c][s];
      end else begin : g_glob
        assign elig[c][s] = src_i[s] & ~mask[c][s] & en[s] & route[s][c];
      end
    end

    irq_router_sel #(.NUM_SRC(NUM_SRC)) u_sel (
      .elig_i(elig[c]), .id_o(ack[c]), .hit_o(hit[c])
    );

    AST_ACK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[c] |-> (ack[c] < SRC_CNT) && elig[c][ack[c][SRC_W-1:0]]);  // R7
    AST_ACK_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit[c] |-> (ack[c] == NONE_ID));  // R7
    AST_PRIV_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i[3] && !mask[c][3]) |-> hit[c] && (ack[c] <= ID_W'(3)));  // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end
  assign irq_o = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> (irq_o == '0));  // R8
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NC = 4;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  cpu = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS-1:0] src = '0;
  logic [NC-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_router uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .cpu_i(cpu),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [39:0] ack;   // {cpu3, cpu2, cpu1, cpu0}, 10 bits each
    logic [3:0]  irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0004, {10'd1023, 10'd1023, 10'd1023, 10'd2},  4'b0001},
    '{32'h0000_0280, {10'd1023, 10'd9,    10'd7,    10'd9},  4'b0111},
    '{32'h0010_0028, {10'd3,    10'd1023, 10'd5,    10'd3},  4'b1011},
    '{32'h0000_000C, {10'd3,    10'd1023, 10'd1023, 10'd2},  4'b1001},
    '{32'h0000_0800, {10'd1023, 10'd1023, 10'd1023, 10'd1023}, 4'b0000},
    '{32'h0010_0000, {10'd20,   10'd1023, 10'd1023, 10'd1023}, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int c, input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; cpu = 2'(c); addr = 12'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input int c, input int a, output logic [31:0] d);
    req = 1; we = 0; cpu = 2'(c); addr = 12'(a);
    #1 d = rdata;
    req = 0;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, d2;
    src = '1;
    repeat (3) @(negedge clk);
    chk("R1 irq low in reset", 32'(irq), 32'h0);
    rst_ni = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 irq low, all masked", 32'(irq), 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(c, 'h044, d);
      chk("R1 ack none after reset", d, 32'd1023);
    end
    rd(0, 'h118, d);
    chk("R1 default route src6", d, 32'h001);
    rd(0, 'h000, d);
    chk("R2 source count", d, 32'(NS) << 2);
    set_src('0);

    // enable without unmask stays invisible
    wr(0, 'h030, 2);
    set_src(32'h4);
    rd(0, 'h044, d);
    chk("R1 masked after reset", d, 32'd1023);

    // configuration
    wr(0, 'h030, 7); wr(0, 'h030, 9); wr(0, 'h030, 20);
    wr(0, 'h100 + 4*7, 32'h002);
    wr(0, 'h100 + 4*9, 32'h005);
    wr(0, 'h100 + 4*20, 32'h800);
    wr(0, 'h04C, 2); wr(0, 'h04C, 9); wr(0, 'h04C, 3);
    wr(1, 'h04C, 7); wr(1, 'h04C, 5);
    wr(2, 'h04C, 9);
    wr(3, 'h04C, 20); wr(3, 'h04C, 3);

    for (int i = 0; i < 6; i++) begin
      set_src(VECS[i].src);
      for (int c = 0; c < NC; c++) begin
        rd(c, 'h044, d);
        chk($sformatf("R7/R6/R5 vec%0d cpu%0d ack", i, c), d, 32'(VECS[i].ack[c*10 +: 10]));
      end
      chk($sformatf("R8 vec%0d irq", i), 32'(irq), 32'(VECS[i].irq));
    end

    // R8: output register lags one edge
    set_src('0);
    @(negedge clk);
    src = 32'h4;
    #1 chk("R8 irq before edge", 32'(irq), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 irq after edge", 32'(irq), 32'h1);

    // R9: ack read is side-effect free
    rd(0, 'h044, d);
    rd(0, 'h044, d2);
    chk("R9 repeat ack", d2, d);
    chk("R9 ack value", d2, 32'd2);
    set_src('0);
    rd(0, 'h044, d);
    chk("R9 cleared by input drop", d, 32'd1023);
    chk("R9 irq drops", 32'(irq), 32'h0);

    // R3: out-of-range index does not alias (41 mod 32 = 9)
    wr(0, 'h034, 41);
    set_src(32'h200);
    rd(0, 'h044, d);
    chk("R3 bad index ignored", d, 32'd9);
    wr(0, 'h034, 9);
    rd(0, 'h044, d);
    chk("R3 enable cleared", d, 32'd1023);

    // R4: mask write touches only the accessing cpu
    wr(1, 'h048, 5);
    set_src(32'h28);
    rd(1, 'h044, d);
    chk("R4 cpu1 masked src5", d, 32'd1023);
    rd(0, 'h044, d);
    chk("R4 cpu0 unaffected", d, 32'd3);
    rd(3, 'h044, d);
    chk("R4 cpu3 unaffected", d, 32'd3);

    // R6: private source ignores enable and route
    wr(0, 'h100 + 4*3, 32'h0);
    rd(3, 'h044, d);
    chk("R6 private ignores route", d, 32'd3);

    // R5: stored bits only
    wr(0, 'h110, 32'hFFFF_FFFF);
    rd(2, 'h110, d);
    chk("R5 route readback", d, 32'h0000_0F0F);
    rd(0, 'h044, d);
    chk("R7 upper bits zero", d & 32'hFFFF_FC00, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule